// File: doc/BRIEF.md
# Dual-Supply Undervoltage Qualifier

This block turns the raw outputs of three supply comparators into clean supply-good flags for a two-channel power switch controller. Two comparators watch the channel supplies, one each. The third watches the higher of the two supplies, which powers the controller. Each comparator bit is high while its supply is above threshold. A falling supply is accepted as bad only after its comparator has stayed low for longer than a glitch window. The window is short for the channel supplies and slightly longer for the global supply. After the global supply comes back, the global-good flag waits for a long turn-on delay before it rises.

The supplies are ranked. A dip on a channel supply drops only that channel's good flag. It sends that channel's controller a one-cycle clear pulse that resets its fault latch, and the channel may restart as soon as its supply returns. A dip on the global supply drops the global flag and both channel flags, clears both channels, and makes the whole turn-on delay run again. All windows are counted in clock cycles. With the defaults at 250 MHz they are 8 µs, 12 µs and 160 ms.

Top module: `uvq_supply_qualifier`

## Requirements
- R1: A channel good-flag stays low until its channel state is good. The channel state goes bad at the clock edge that samples `ch_raw[i]` low for the (CH_FILT_CYC+1)-th time in a row. A low run of CH_FILT_CYC samples or fewer leaves it unchanged, and any high sample restarts the count from zero.
- R2: The filtered global state goes bad at the edge that samples `gl_raw` low for the (GL_FILT_CYC+1)-th time in a row. Shorter low runs have no effect, and a high sample restarts the count. `gl_good` falls in the same cycle as the filtered state.
- R3: Start from a bad filtered global state. `gl_good` rises at the edge that samples `gl_raw` high for the (TURNON_CYC+1)-th time in a row. Low runs too short to trip R2 do not restart or stall this delay.
- R4: While `gl_good` is 1, a channel whose raw bit is sampled high has `ch_good[i]` = 1 from the next cycle on, with no additional delay.
- R5: `ch_good[i]` is never 1 while `gl_good` is 0. When `gl_good` falls, every channel good-flag that was 1 falls in the same cycle.
- R6: `ch_clr[i]` is 1 for exactly one cycle: the first cycle in which `ch_good[i]` is 0 after a cycle in which it was 1. It is 0 at all other times.
- R7: A channel supply going bad changes neither the good-flag nor the clear strobe of the other channel.
- R8: During reset and in the first cycle after reset, all outputs are 0. `gl_good` rises no earlier than TURNON_CYC+1 edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_raw | input | NUM_CH | Raw channel-supply comparator bits, 1 = above threshold |
| gl_raw | input | 1 | Raw higher-supply comparator bit, 1 = above threshold |
| ch_good | output | NUM_CH | Qualified per-channel supply-good flags |
| gl_good | output | 1 | Qualified global supply-good flag |
| ch_clr | output | NUM_CH | One-cycle fault-clear strobes for the channel controllers |

## Verification
Every result is due in the cycle that follows a clock edge. A channel flag falls right after the edge that takes the (CH_FILT_CYC+1)-th low sample, and it rises one edge after a high sample. `gl_good` falls right after the (GL_FILT_CYC+1)-th low edge and rises right after the (TURNON_CYC+1)-th high edge. A clear strobe appears in the same cycle that its flag falls. The bench changes inputs on the falling clock edge and lets one rising edge pass. It then updates its edge-by-edge reference state and compares every output at the next falling edge. Directed checks are placed at exactly these boundary edges: one sample before each threshold and at the threshold itself.

// File: rtl/uvq_pkg.sv
// Package: shared helpers for the undervoltage qualifier.
// Assumes: limits passed to cnt_w are at least 1.
package uvq_pkg;

    // Counter width needed to hold values 0..limit.
    function automatic int cnt_w(input int limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/uvq_fall_filter.sv
// Module: falling-edge glitch filter for one comparator bit.
// The qualified flag recovers on the first high sample. It drops only on
// the (LIMIT+1)-th consecutive low sample. Assumes LIMIT >= 1 and that
// raw is already synchronous to clk.
module uvq_fall_filter #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic ok
);
    import uvq_pkg::*;

    localparam int W = cnt_w(LIMIT);

    logic [W-1:0] low_cnt;

    // Count consecutive low samples and clear the flag once the window is exceeded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            ok      <= 1'b0;
        end else if (raw) begin
            low_cnt <= '0;
            ok      <= 1'b1;
        end else if (low_cnt == W'(LIMIT)) begin
            ok      <= 1'b0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uvq_turnon_delay.sv
// Module: turn-on delay for the filtered global flag.
// The output rises after ok_in has been 1 before DELAY consecutive edges.
// It falls in the same cycle that ok_in falls. Assumes DELAY >= 2.
module uvq_turnon_delay #(
    parameter int DELAY = 40_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_in,
    output logic good
);
    import uvq_pkg::*;

    localparam int W = cnt_w(DELAY);

    logic [W-1:0] run_cnt;
    logic         armed;

    // Count good edges up to DELAY; restart the count whenever the input drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !ok_in) begin
            run_cnt <= '0;
            armed   <= 1'b0;
        end else if (!armed) begin
            if (run_cnt == W'(DELAY - 1)) begin
                armed <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Gate with the live input so a global drop takes effect at once.
    assign good = armed & ok_in;

endmodule

// File: rtl/uvq_clear_strobe.sv
// Module: falling-edge detector that makes a one-cycle clear pulse.
// The pulse is high in the first cycle the flag is low after a high cycle.
module uvq_clear_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic clr
);
    logic flag_q;

    // Remember the flag value from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag;
    end

    // Pulse while the old value was high and the new one is low.
    assign clr = flag_q & ~flag;

endmodule

// File: rtl/uvq_supply_qualifier.sv
// Module: dual-supply undervoltage qualifier (top).
// It filters the channel and global comparator bits and applies the
// turn-on delay to the global flag. Each channel flag is gated by the
// global flag, and a clear strobe is made for each channel.
// Assumes: comparator bits are synchronous to clk; CH_FILT_CYC >= 1,
// GL_FILT_CYC >= 1, TURNON_CYC >= 2.
module uvq_supply_qualifier #(
    parameter int NUM_CH      = 2,
    parameter int CH_FILT_CYC = 2000,
    parameter int GL_FILT_CYC = 3000,
    parameter int TURNON_CYC  = 40_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_raw,
    input  logic              gl_raw,
    output logic [NUM_CH-1:0] ch_good,
    output logic              gl_good,
    output logic [NUM_CH-1:0] ch_clr
);
    logic              gl_filt;
    logic [NUM_CH-1:0] ch_ok;

    // Global supply: glitch filter followed by the long turn-on delay.
    uvq_fall_filter #(.LIMIT(GL_FILT_CYC)) u_gl_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (gl_raw),
        .ok    (gl_filt)
    );

    uvq_turnon_delay #(.DELAY(TURNON_CYC)) u_gl_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .ok_in (gl_filt),
        .good  (gl_good)
    );

    // Per-channel filter, global gating and clear strobe.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        uvq_fall_filter #(.LIMIT(CH_FILT_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (ch_raw[i]),
            .ok    (ch_ok[i])
        );

        assign ch_good[i] = ch_ok[i] & gl_good;

        uvq_clear_strobe u_clr (
            .clk   (clk),
            .rst_n (rst_n),
            .flag  (ch_good[i]),
            .clr   (ch_clr[i])
        );
    end

endmodule

// File: rtl/uvq_checker.sv
// Module: property checker for the qualifier, attached by bind.
module uvq_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_raw,
    input logic              gl_raw,
    input logic [NUM_CH-1:0] ch_good,
    input logic              gl_good,
    input logic [NUM_CH-1:0] ch_clr
);
    AST_GL_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(gl_good) |-> !$past(gl_raw)); // R2
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (!gl_good && ch_good == '0 && ch_clr == '0)); // R8

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_CH_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n) ch_good[i] |-> gl_good); // R5
        AST_CH_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ch_good[i]) && gl_good) |-> !$past(ch_raw[i])); // R1
        AST_CH_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ch_good[i]) && $past(gl_good)) |-> $past(ch_raw[i])); // R4
        AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) ch_clr[i] |-> ($past(ch_good[i]) && !ch_good[i])); // R6
        AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ch_clr[i] |=> !ch_clr[i]); // R6
    end

endmodule

bind uvq_supply_qualifier uvq_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_raw  (ch_raw),
    .gl_raw  (gl_raw),
    .ch_good (ch_good),
    .gl_good (gl_good),
    .ch_clr  (ch_clr)
);

// File: tb/sim_uvq_supply_qualifier.sv
`timescale 1ns/1ps
module sim_uvq_supply_qualifier;
    localparam int CH_LIM = 5;
    localparam int GL_LIM = 8;
    localparam int TON    = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ch_raw = 2'b11;
    logic       gl_raw = 1'b1;
    logic [1:0] ch_good;
    logic [1:0] ch_clr;
    logic       gl_good;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state, advanced once per rising edge.
    int m_run[2];
    bit m_ok[2];
    bit m_prev[2];
    int m_grun;
    bit m_gfilt;
    int m_drun;
    bit m_dgood;

    always #2 clk = ~clk;

    uvq_supply_qualifier #(
        .NUM_CH(2), .CH_FILT_CYC(CH_LIM), .GL_FILT_CYC(GL_LIM), .TURNON_CYC(TON)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ch_raw(ch_raw), .gl_raw(gl_raw),
        .ch_good(ch_good), .gl_good(gl_good), .ch_clr(ch_clr)
    );

    function automatic bit e_gl();
        return m_dgood & m_gfilt;
    endfunction

    function automatic bit e_ch(input int i);
        return m_ok[i] & e_gl();
    endfunction

    function automatic bit e_clr(input int i);
        return m_prev[i] & !e_ch(i);
    endfunction

    task automatic model_edge();
        bit old_g[2];
        bit old_gf;
        for (int i = 0; i < 2; i++) old_g[i] = e_ch(i);
        old_gf = m_gfilt;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_run[i] = 0; m_ok[i] = 0; m_prev[i] = 0;
            end
            m_grun = 0; m_gfilt = 0; m_drun = 0; m_dgood = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (ch_raw[i]) begin m_run[i] = 0; m_ok[i] = 1; end
                else begin
                    m_run[i]++;
                    if (m_run[i] >= CH_LIM + 1) m_ok[i] = 0;
                end
                m_prev[i] = old_g[i];
            end
            if (gl_raw) begin m_grun = 0; m_gfilt = 1; end
            else begin
                m_grun++;
                if (m_grun >= GL_LIM + 1) m_gfilt = 0;
            end
            if (!old_gf) begin m_drun = 0; m_dgood = 0; end
            else begin
                m_drun++;
                if (m_drun >= TON) m_dgood = 1;
            end
        end
    endtask

    task automatic cmp(input string tag);
        logic [1:0] eg, ec;
        eg = {e_ch(1), e_ch(0)};
        ec = {e_clr(1), e_clr(0)};
        n_vec++;
        if (ch_good !== eg || ch_clr !== ec || gl_good !== e_gl()) begin
            n_bad++;
            $display("FAIL %s: good=%b clr=%b gl=%b expected good=%b clr=%b gl=%b",
                     tag, ch_good, ch_clr, gl_good, eg, ec, e_gl());
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    task automatic expect1(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_0042);
        @(negedge clk);
        ticks(3, "R8 in reset");
        expect1("R8 gl_good in reset", gl_good, 1'b0);
        expect1("R8 ch_good in reset", |ch_good, 1'b0);
        rst_n = 1'b1;
        tick("R8 first cycle");
        expect1("R8 gl_good after release", gl_good, 1'b0);
        ticks(TON - 1, "R8 delay");
        expect1("R8 gl_good one edge early", gl_good, 1'b0);
        tick("R3 delay end");
        expect1("R3 gl_good at TON+1 highs", gl_good, 1'b1);
        expect1("R4 both channels good", &ch_good, 1'b1);

        // Channel 0 glitch exactly at the window, then one sample longer.
        ch_raw[0] = 1'b0;
        ticks(CH_LIM, "R1 short dip");
        expect1("R1 ch0 holds after CH_LIM lows", ch_good[0], 1'b1);
        ch_raw[0] = 1'b1;
        tick("R1 restart");
        ch_raw[0] = 1'b0;
        ticks(CH_LIM + 1, "R1 long dip");
        expect1("R1 ch0 drops", ch_good[0], 1'b0);
        expect1("R6 ch0 clear pulse", ch_clr[0], 1'b1);
        expect1("R7 ch1 unaffected", ch_good[1], 1'b1);
        expect1("R7 ch1 no clear", ch_clr[1], 1'b0);
        expect1("R7 gl_good unaffected", gl_good, 1'b1);
        tick("R6 pulse end");
        expect1("R6 clear single cycle", ch_clr[0], 1'b0);
        ch_raw[0] = 1'b1;
        tick("R4 recover");
        expect1("R4 ch0 immediate restart", ch_good[0], 1'b1);

        // Global glitch at the window, then one sample longer.
        gl_raw = 1'b0;
        ticks(GL_LIM, "R2 short dip");
        expect1("R2 gl holds after GL_LIM lows", gl_good, 1'b1);
        gl_raw = 1'b1;
        tick("R2 restart");
        gl_raw = 1'b0;
        ticks(GL_LIM + 1, "R2 long dip");
        expect1("R2 gl_good drops", gl_good, 1'b0);
        expect1("R5 channels forced off", |ch_good, 1'b0);
        expect1("R5 both cleared", &ch_clr, 1'b1);
        gl_raw = 1'b1;
        ticks(TON, "R3 re-entry");
        expect1("R3 gl_good still waiting", gl_good, 1'b0);
        tick("R3 re-entry end");
        expect1("R3 gl_good after re-entry delay", gl_good, 1'b1);

        // Short global dip during the turn-on delay must not restart it.
        gl_raw = 1'b0;
        ticks(GL_LIM + 1, "R2 drop again");
        gl_raw = 1'b1;
        ticks(10, "R3 partial delay");
        gl_raw = 1'b0;
        ticks(3, "R3 short dip in delay");
        gl_raw = 1'b1;
        ticks(TON + 1 - 13 - 1, "R3 delay rest");
        expect1("R3 gl_good one edge early", gl_good, 1'b0);
        tick("R3 delay done");
        expect1("R3 dip did not restart delay", gl_good, 1'b1);

        // Random bursts on all three comparator bits.
        for (int c = 0; c < 6000; c++) begin
            for (int i = 0; i < 2; i++) begin
                if (ch_raw[i]) begin if ($urandom_range(15) == 0) ch_raw[i] = 1'b0; end
                else if ($urandom_range(3) == 0) ch_raw[i] = 1'b1;
            end
            if (gl_raw) begin if ($urandom_range(79) == 0) gl_raw = 1'b0; end
            else if ($urandom_range(5) == 0) gl_raw = 1'b1;
            tick("R1 R2 R3 R5 R6 R7 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule